// File: doc/BRIEF.md
# Registered Two-Port Bus Transceiver

The block links two data ports, A and B, through a pair of capture registers. The A-to-B register samples the A input on the rising edge of its own clock. The B-to-A register samples the B input on the rising edge of a second clock. Sampling happens on every rising edge, whatever the drive controls are set to.

An active-low enable and a direction bit choose which port, if either, is driven. When a port is driven, a per-direction select picks its data. The data is either the live value arriving on the opposite port or the value held in that direction's register. The data path is split into independent lanes of equal width, and each lane has its own complete control set. Each port is modelled as an input vector, an output vector and a per-lane output-enable flag. There are no tri-state pins.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_n` is low, both capture registers of every lane are cleared to zero. After reset, the driven output shows zero when stored data is selected.
- R2: The A-to-B register of a lane loads that lane's `a_in` bits on each rising edge of `cap_ab[i]`, whatever the lane's enable, direction and select inputs are.
- R3: The B-to-A register of a lane loads that lane's `b_in` bits on each rising edge of `cap_ba[i]`, whatever the lane's enable, direction and select inputs are.
- R4: When `en_n[i]` is 1, neither `a_oe[i]` nor `b_oe[i]` is asserted, and both registers of the lane still capture data.
- R5: When `en_n[i]` is 0, `dir[i]` = 0 asserts `a_oe[i]` (B feeds A) and `dir[i]` = 1 asserts `b_oe[i]` (A feeds B).
- R6: While the A side is driven, `sel_ba[i]` = 0 puts the live `b_in` lane bits on `a_out`, and `sel_ba[i]` = 1 puts the stored B-to-A register value on `a_out`.
- R7: While the B side is driven, `sel_ab[i]` = 0 puts the live `a_in` lane bits on `b_out`, and `sel_ab[i]` = 1 puts the stored A-to-B register value on `b_out`.
- R8: `a_oe[i]` and `b_oe[i]` are never both 1.
- R9: Lane i occupies bits [LANE_W*i +: LANE_W] of every data vector. A lane's controls and clocks affect only its own bits and flags.
- R10: The output bits of a lane that is not driven read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of all capture registers |
| en_n | input | LANES | Active-low drive enable per lane |
| dir | input | LANES | Direction per lane: 0 drives A, 1 drives B |
| cap_ab | input | LANES | Rising-edge capture clock of the A-to-B register per lane |
| cap_ba | input | LANES | Rising-edge capture clock of the B-to-A register per lane |
| sel_ab | input | LANES | B-side source: 0 live A, 1 stored A |
| sel_ba | input | LANES | A-side source: 0 live B, 1 stored B |
| a_in | input | LANE_W*LANES | Data arriving on port A |
| b_in | input | LANE_W*LANES | Data arriving on port B |
| a_out | output | LANE_W*LANES | Data driven onto port A |
| b_out | output | LANE_W*LANES | Data driven onto port B |
| a_oe | output | LANES | Port A drive flag per lane |
| b_oe | output | LANES | Port B drive flag per lane |

## Verification
Two functions can coincide in the same cycle. A capture edge can arrive while the port that shows the stored register is being driven. A lane can also capture while it is isolated. The bench selects stored data on a driven port, pulses that direction's clock with new input data, and expects the output to change to the new value right after the edge. It also isolates a lane, captures on both sides, and then enables each direction with stored data selected to read back what was captured. A full sweep of every control combination on each lane follows. In that sweep the other lane is held isolated so that any leak across lanes shows up.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int W = LANE_W * LANES
) (
  input  logic             rst_n,
  input  logic [LANES-1:0] en_n,
  input  logic [LANES-1:0] dir,
  input  logic [LANES-1:0] cap_ab,
  input  logic [LANES-1:0] cap_ba,
  input  logic [LANES-1:0] sel_ab,
  input  logic [LANES-1:0] sel_ba,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     b_in,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     b_out,
  output logic [LANES-1:0] a_oe,
  output logic [LANES-1:0] b_oe
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] ab_q, ba_q;
    logic [LANE_W-1:0] a_src, b_src;

    always_ff @(posedge cap_ab[g] or negedge rst_n)
      if (!rst_n) ab_q <= '0;
      else        ab_q <= a_in[g*LANE_W +: LANE_W];

    always_ff @(posedge cap_ba[g] or negedge rst_n)
      if (!rst_n) ba_q <= '0;
      else        ba_q <= b_in[g*LANE_W +: LANE_W];

    assign a_oe[g] = ~en_n[g] & ~dir[g];
    assign b_oe[g] = ~en_n[g] &  dir[g];

    // AND-OR selection: both legs are qualified separately, no decoder in the path
    assign a_src = ({LANE_W{~sel_ba[g]}} & b_in[g*LANE_W +: LANE_W])
                 | ({LANE_W{ sel_ba[g]}} & ba_q);
    assign b_src = ({LANE_W{~sel_ab[g]}} & a_in[g*LANE_W +: LANE_W])
                 | ({LANE_W{ sel_ab[g]}} & ab_q);

    assign a_out[g*LANE_W +: LANE_W] = a_src & {LANE_W{a_oe[g]}};
    assign b_out[g*LANE_W +: LANE_W] = b_src & {LANE_W{b_oe[g]}};

    always_comb begin
      p_one_driver_r8: assert (!(a_oe[g] && b_oe[g]));
      if (en_n[g]) begin
        p_isolate_r4: assert (!a_oe[g] && !b_oe[g]);
      end
      if (!a_oe[g]) begin
        p_quiet_a_r10: assert (a_out[g*LANE_W +: LANE_W] == '0);
      end
      if (!b_oe[g]) begin
        p_quiet_b_r10: assert (b_out[g*LANE_W +: LANE_W] == '0);
      end
    end
  end

endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int LW = 8;
  localparam int NL = 2;
  localparam int W  = LW * NL;

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [NL-1:0] en_n, dir, cap_ab, cap_ba, sel_ab, sel_ba, a_oe, b_oe;
  logic [W-1:0] a_in, b_in, a_out, b_out;

  bus_xcvr_reg #(.LANE_W(LW), .LANES(NL)) u0 (
    .rst_n(rst_n), .en_n(en_n), .dir(dir), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe));

  int checks = 0, fails = 0;
  logic [LW-1:0] m_ab [NL];
  logic [LW-1:0] m_ba [NL];

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(int lane, bit ab, bit ba);
    @(negedge clk);
    if (ab) cap_ab[lane] = 1'b1;
    if (ba) cap_ba[lane] = 1'b1;
    @(negedge clk);
    cap_ab = '0; cap_ba = '0;
    if (ab) m_ab[lane] = a_in[lane*LW +: LW];
    if (ba) m_ba[lane] = b_in[lane*LW +: LW];
  endtask

  task automatic check_lane(int l);
    logic [LW-1:0] ea, eb;
    logic ao, bo;
    ao = !en_n[l] && !dir[l];
    bo = !en_n[l] && dir[l];
    ea = ao ? (sel_ba[l] ? m_ba[l] : b_in[l*LW +: LW]) : '0;
    eb = bo ? (sel_ab[l] ? m_ab[l] : a_in[l*LW +: LW]) : '0;
    chk("R5 a_oe", W'(a_oe[l]), W'(ao));
    chk("R5 b_oe", W'(b_oe[l]), W'(bo));
    chk("R8 exclusive", W'(a_oe[l] & b_oe[l]), '0);
    if (en_n[l]) chk("R4 isolation", W'(a_oe[l] | b_oe[l]), '0);
    chk(ao ? "R6 a_out" : "R10 a_out quiet", W'(a_out[l*LW +: LW]), W'(ea));
    chk(bo ? "R7 b_out" : "R10 b_out quiet", W'(b_out[l*LW +: LW]), W'(eb));
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; en_n = '1; dir = '0; cap_ab = '0; cap_ba = '0;
    sel_ab = '0; sel_ba = '0; a_in = '0; b_in = '0;
    for (int i = 0; i < NL; i++) begin m_ab[i] = '0; m_ba[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: stored data after reset is zero
    a_in = 16'hA5C3; b_in = 16'h5A3C;
    en_n = '0; dir = '1; sel_ab = '1; #1;
    chk("R1 stored A after reset", b_out, '0);
    dir = '0; sel_ba = '1; #1;
    chk("R1 stored B after reset", a_out, '0);

    // R2/R3 same-cycle: capture while the stored value is being driven
    for (int l = 0; l < NL; l++) begin
      en_n = '1; en_n[l] = 0; dir = '0; dir[l] = 1; sel_ab = '1;
      a_in[l*LW +: LW] = LW'(8'h31 + l * 7);
      pulse(l, 1, 0); #1;
      chk("R2 capture while driving stored", W'(b_out[l*LW +: LW]), W'(m_ab[l]));
      dir[l] = 0; sel_ba = '1;
      b_in[l*LW +: LW] = LW'(8'hC4 - l * 5);
      pulse(l, 0, 1); #1;
      chk("R3 capture while driving stored", W'(a_out[l*LW +: LW]), W'(m_ba[l]));
    end

    // R4: capture during isolation, then read back
    for (int l = 0; l < NL; l++) begin
      en_n = '1;
      a_in[l*LW +: LW] = LW'(8'h69 ^ l);
      b_in[l*LW +: LW] = LW'(8'h96 ^ (l << 4));
      pulse(l, 1, 1);
      a_in = '0; b_in = '1;
      en_n[l] = 0; dir[l] = 1; sel_ab[l] = 1; #1;
      chk("R4 isolated capture A->B", W'(b_out[l*LW +: LW]), W'(8'h69 ^ l));
      dir[l] = 0; sel_ba[l] = 1; #1;
      chk("R4 isolated capture B->A", W'(a_out[l*LW +: LW]), W'(8'h96 ^ (l << 4)));
    end

    // Sweep of every control combination per lane; other lane isolated (R9)
    for (int l = 0; l < NL; l++) begin
      for (int p = 0; p < 4; p++) begin
        for (int c = 0; c < 16; c++) begin
          int o;
          o = 1 - l;
          en_n[o] = 1; dir[o] = c[0]; sel_ab[o] = c[1]; sel_ba[o] = c[2];
          en_n[l] = c[0]; dir[l] = c[1]; sel_ab[l] = c[2]; sel_ba[l] = c[3];
          a_in = W'((p * 16 + c) * 16'h0923 + 16'h1111);
          b_in = W'((p * 16 + c) * 16'h3A57 + 16'h0F0F);
          pulse(l, (c % 3) != 0, (c % 2) == 0);
          #1;
          check_lane(l);
          chk("R9 idle lane a_out", W'(a_out[o*LW +: LW]), '0);
          chk("R9 idle lane b_out", W'(b_out[o*LW +: LW]), '0);
          chk("R9 idle lane flags", W'({a_oe[o], b_oe[o]}), '0);
          a_in = ~a_in; b_in = b_in ^ 16'h5555; #1;
          check_lane(l);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule